// File: doc/BRIEF.md
# Redundant value block arithmetic unit

This block executes electronic-purse commands against a bank of 16-byte value blocks that it holds itself. A caller presents one command per cycle: a plain read or write of a whole block, an increment or decrement by an unsigned amount, a restore, or a transfer. Increment, decrement and restore compute into a 32-bit holding register and never touch the bank. Only a transfer moves the holding register back into a block.

A value block carries its signed 32-bit value three times, one of those copies inverted. It carries its address byte four times, two of those copies inverted. Before any value operation the unit checks that these copies agree. A block that fails this check is refused with an error. Each command is answered exactly one cycle later with a done pulse, and with an error flag if it was refused. Read data appears on the same cycle as the done pulse.

Top module: `vb_purse_unit`

## Requirements
- R1: After reset, `done_o` and `err_o` are 0, `rd_data_o` is all zeros, every stored block is all zeros, and the holding register is marked invalid.
- R2: Every cycle with `cmd_valid_i` high yields a one-cycle `done_o` on the next cycle. `done_o` is low in the cycle after an idle cycle. `err_o` is never high without `done_o`.
- R3: Write (code 1) stores `wr_data_i` verbatim into the addressed block, whether or not it is in value format. Read (code 0) drives the addressed block on `rd_data_o` in the done cycle. Block byte k sits at bits [8k+7:8k]. `rd_data_o` keeps its last read result through all other commands.
- R4: The value format is as follows. Bytes 0..3 hold the value, least significant byte first. Bytes 4..7 hold its bitwise inverse, and bytes 8..11 hold a second plain copy. Bytes 12 and 14 hold the address byte, and bytes 13 and 15 hold its inverse. Increment, decrement and restore on a block that breaks any of these rules raise `err_o`. They leave the holding register value unchanged but mark it invalid.
- R5: Increment (code 2) loads the holding register with the block value plus `cmd_arg_i`, modulo 2^32, and leaves the bank unchanged.
- R6: Decrement (code 3) loads the holding register with the block value minus `cmd_arg_i`, modulo 2^32, and leaves the bank unchanged.
- R7: Restore (code 4) loads the holding register with the block value unchanged.
- R8: Transfer (code 5) rewrites bytes 0..11 of the target block in value format from the holding register. Bytes 12..15 keep their old contents.
- R9: A transfer is refused with `err_o` and the bank is left unchanged when the holding register is invalid or the target block breaks the format. The register is invalid after reset and after any refused command.
- R10: Codes 6 and 7 are refused with `err_o` and change no block.
- R11: A command sees the bank as updated by the command of the immediately preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Command code |
| cmd_blk_i | input | BLK_W (4) | Block number |
| cmd_arg_i | input | 32 | Increment/decrement amount |
| wr_data_i | input | 128 | Block contents for write |
| done_o | output | 1 | Command answered |
| err_o | output | 1 | Command refused |
| rd_data_o | output | 128 | Last read block |

## Verification
Two functions share a cycle boundary in this block. One is the bank update of one command; the other is the format check and value fetch of the next command, which work on the same block. The bench provokes this by issuing a write and then, with no gap, an increment of that block, and also a transfer followed at once by a read. The bench judges both cases against its own model, which applies each command in order. A refused command followed at once by a transfer also tests the invalidation of the register in the same sequence.

// File: rtl/vb_pkg.sv
package vb_pkg;
  localparam int VAL_W = 32;
  localparam int BLK_BITS = 128;

  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_WRITE   = 3'd1,
    OP_INC     = 3'd2,
    OP_DEC     = 3'd3,
    OP_RESTORE = 3'd4,
    OP_XFER    = 3'd5
  } vb_op_e;

  function automatic logic [BLK_BITS-1:0] vb_pack(input logic [VAL_W-1:0] val,
                                                  input logic [31:0] adr_bytes);
    return {adr_bytes, val, ~val, val};
  endfunction
endpackage

// File: rtl/vb_fmt.sv
module vb_fmt
  import vb_pkg::*;
(
  input  logic [BLK_BITS-1:0] blk_i,
  output logic                ok_o,
  output logic [VAL_W-1:0]    val_o
);
  logic [7:0] a0, a1, a2, a3;
  logic       val_ok, adr_ok;

  assign a0 = blk_i[103:96];
  assign a1 = blk_i[111:104];
  assign a2 = blk_i[119:112];
  assign a3 = blk_i[127:120];

  assign val_ok = (blk_i[31:0] == blk_i[95:64]) && (blk_i[31:0] == ~blk_i[63:32]);
  assign adr_ok = (a0 == a2) && (a1 == a3) && (a1 == ~a0);
  assign ok_o   = val_ok && adr_ok;
  assign val_o  = blk_i[31:0];
endmodule

// File: rtl/vb_alu.sv
module vb_alu
  import vb_pkg::*;
(
  input  vb_op_e           op_i,
  input  logic [VAL_W-1:0] val_i,
  input  logic [VAL_W-1:0] arg_i,
  output logic [VAL_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_INC:  res_o = val_i + arg_i;
      OP_DEC:  res_o = val_i - arg_i;
      default: res_o = val_i;
    endcase
  end
endmodule

// File: rtl/vb_store.sv
module vb_store
  import vb_pkg::*;
#(
  parameter int NBLK  = 16,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [BLK_W-1:0]                widx_i,
  input  logic [BLK_BITS-1:0]             wdata_i,
  output logic [NBLK-1:0][BLK_BITS-1:0]   blocks_o
);
  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                blocks_o[g] <= '0;
      else if (we_i && widx_i == BLK_W'(g))       blocks_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/vb_purse_unit.sv
module vb_purse_unit
  import vb_pkg::*;
#(
  parameter int NBLK  = 16,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [2:0]          cmd_op_i,
  input  logic [BLK_W-1:0]    cmd_blk_i,
  input  logic [VAL_W-1:0]    cmd_arg_i,
  input  logic [BLK_BITS-1:0] wr_data_i,
  output logic                done_o,
  output logic                err_o,
  output logic [BLK_BITS-1:0] rd_data_o
);
  logic [NBLK-1:0][BLK_BITS-1:0] blocks;
  logic [BLK_BITS-1:0] cur_blk, wdata;
  logic [VAL_W-1:0]    cur_val, alu_res, reg_val_q;
  logic                cur_ok, reg_vld_q;
  logic                we, fail, reg_ld, rd_ld;
  vb_op_e              op;

  assign op      = vb_op_e'(cmd_op_i);
  assign cur_blk = blocks[cmd_blk_i];

  vb_fmt u_fmt (.blk_i(cur_blk), .ok_o(cur_ok), .val_o(cur_val));
  vb_alu u_alu (.op_i(op), .val_i(cur_val), .arg_i(cmd_arg_i), .res_o(alu_res));

  always_comb begin
    we = 1'b0; fail = 1'b0; reg_ld = 1'b0; rd_ld = 1'b0;
    wdata = wr_data_i;
    if (cmd_valid_i) begin
      unique case (op)
        OP_READ:  rd_ld = 1'b1;
        OP_WRITE: we = 1'b1;
        OP_INC, OP_DEC, OP_RESTORE: begin
          if (cur_ok) reg_ld = 1'b1;
          else        fail = 1'b1;
        end
        OP_XFER: begin
          if (cur_ok && reg_vld_q) begin
            we    = 1'b1;
            wdata = vb_pack(reg_val_q, cur_blk[127:96]);
          end else fail = 1'b1;
        end
        default: fail = 1'b1;
      endcase
    end
  end

  vb_store #(.NBLK(NBLK)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .widx_i(cmd_blk_i),
    .wdata_i(wdata), .blocks_o(blocks)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      rd_data_o <= '0;
      reg_val_q <= '0;
      reg_vld_q <= 1'b0;
    end else begin
      done_o <= cmd_valid_i;
      err_o  <= fail;
      if (rd_ld) rd_data_o <= cur_blk;
      if (fail) reg_vld_q <= 1'b0;
      else if (reg_ld) begin
        reg_val_q <= alu_res;
        reg_vld_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vb_purse_chk.sv
module vb_purse_chk
  import vb_pkg::*;
#(
  parameter int NBLK  = 16,
  localparam int BLK_W = $clog2(NBLK)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          cmd_valid_i,
  input logic [2:0]                    cmd_op_i,
  input logic [BLK_W-1:0]              cmd_blk_i,
  input logic                          done_o,
  input logic                          err_o,
  input logic [VAL_W-1:0]              reg_val,
  input logic                          reg_vld,
  input logic [NBLK-1:0][BLK_BITS-1:0] blocks
);
  logic [2:0]       prev_op;
  logic [BLK_W-1:0] prev_blk;
  logic [31:0]      prev_adr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_op <= 3'd0; prev_blk <= '0; prev_adr <= '0;
    end else begin
      prev_op  <= cmd_op_i;
      prev_blk <= cmd_blk_i;
      prev_adr <= blocks[cmd_blk_i][127:96];
    end
  end

  assert_resp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> done_o);
  assert_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !done_o);
  assert_err_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  assert_reg_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(reg_val) && !reg_vld);
  assert_xfer_invalid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd5 && !reg_vld) |=> err_o);
  assert_adr_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && prev_op == 3'd5) |-> blocks[prev_blk][127:96] == prev_adr);
  assert_bad_op_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i > 3'd5) |=> err_o);
endmodule

bind vb_purse_unit vb_purse_chk #(.NBLK(NBLK)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
  .cmd_blk_i(cmd_blk_i), .done_o(done_o), .err_o(err_o),
  .reg_val(reg_val_q), .reg_vld(reg_vld_q), .blocks(blocks)
);

// File: tb/sim_vb_purse_unit.sv
`timescale 1ns/1ps
module sim_vb_purse_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cmd_valid_i = 1'b0;
  logic [2:0]   cmd_op_i = '0;
  logic [3:0]   cmd_blk_i = '0;
  logic [31:0]  cmd_arg_i = '0;
  logic [127:0] wr_data_i = '0;
  logic         done_o, err_o;
  logic [127:0] rd_data_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [127:0] mm [16];
  logic [31:0]  mreg;
  bit           mvld;
  logic [127:0] exp_rd;

  always #2.5 clk_i = ~clk_i;

  vb_purse_unit u0 (.*);

  function automatic logic [127:0] mk(input logic [31:0] v, input logic [7:0] a);
    logic [127:0] b;
    for (int i = 0; i < 4; i++) begin
      b[8*i +: 8]      = v[8*i +: 8];
      b[8*(i+4) +: 8]  = ~v[8*i +: 8];
      b[8*(i+8) +: 8]  = v[8*i +: 8];
    end
    b[103:96] = a; b[111:104] = ~a; b[119:112] = a; b[127:120] = ~a;
    return b;
  endfunction

  function automatic bit good(input logic [127:0] b);
    bit ok = 1;
    for (int i = 0; i < 4; i++)
      if (b[8*i +: 8] != b[8*(i+8) +: 8] || b[8*i +: 8] != ~b[8*(i+4) +: 8]) ok = 0;
    if (b[103:96] != b[119:112] || b[111:104] != b[127:120] || b[111:104] != ~b[103:96]) ok = 0;
    return ok;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, compare at following negedge
  task automatic cmd(input logic [2:0] op, input logic [3:0] blk, input logic [31:0] arg,
                     input logic [127:0] d, input string req);
    bit e = 0;
    cmd_valid_i = 1; cmd_op_i = op; cmd_blk_i = blk; cmd_arg_i = arg; wr_data_i = d;
    case (op)
      3'd0: exp_rd = mm[blk];
      3'd1: mm[blk] = d;
      3'd2, 3'd3, 3'd4: begin
        if (!good(mm[blk])) e = 1;
        else begin
          mreg = (op == 3'd2) ? mm[blk][31:0] + arg :
                 (op == 3'd3) ? mm[blk][31:0] - arg : mm[blk][31:0];
          mvld = 1;
        end
      end
      3'd5: begin
        if (!mvld || !good(mm[blk])) e = 1;
        else mm[blk] = mk(mreg, mm[blk][103:96]);
      end
      default: e = 1;
    endcase
    if (e) mvld = 0;
    @(negedge clk_i);
    chk({req, " done"}, 128'(done_o), 128'(1'b1));
    chk({req, " err"}, 128'(err_o), 128'(e));
    chk({req, " rd_data"}, rd_data_o, exp_rd);
  endtask

  task automatic idle(input int n);
    cmd_valid_i = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      chk("R2 idle done", 128'(done_o), 128'(1'b0));
      chk("R2 idle err", 128'(err_o), 128'(1'b0));
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mm[i] = '0;
    mreg = '0; mvld = 0; exp_rd = '0;
    #12 @(negedge clk_i);
    chk("R1 done", 128'(done_o), 128'(1'b0));
    chk("R1 err", 128'(err_o), 128'(1'b0));
    chk("R1 rd_data", rd_data_o, '0);
    rst_ni = 1;
    @(negedge clk_i);
    // R1/R9: transfer with register invalid after reset, target zeros
    cmd(3'd5, 4'd2, 0, '0, "R9 xfer after reset");
    cmd(3'd0, 4'd2, 0, '0, "R1 zero block");
    // R3: example block 1234567 at address 0x11
    chk("R4 layout", mk(32'd1234567, 8'h11), 128'hEE11EE110012D687FFED29780012D687);
    cmd(3'd1, 4'd1, 0, 128'hEE11EE110012D687FFED29780012D687, "R3 write");
    cmd(3'd0, 4'd1, 0, '0, "R3 read");
    cmd(3'd1, 4'd2, 0, mk(32'd5, 8'h22), "R3 write2");
    // R7 restore then R8 transfer keeps address bytes of target
    cmd(3'd4, 4'd1, 0, '0, "R7 restore");
    cmd(3'd5, 4'd2, 0, '0, "R8 xfer");
    cmd(3'd0, 4'd2, 0, '0, "R8 readback");
    chk("R8 value", rd_data_o, mk(32'd1234567, 8'h22));
    // R5 increment, memory untouched until transfer
    cmd(3'd2, 4'd1, 32'd1000, '0, "R5 inc");
    cmd(3'd0, 4'd1, 0, '0, "R5 bank unchanged");
    cmd(3'd5, 4'd1, 0, '0, "R5 xfer");
    cmd(3'd0, 4'd1, 0, '0, "R5 readback");
    chk("R5 value", rd_data_o, mk(32'd1235567, 8'h11));
    // R6 decrement to negative
    cmd(3'd3, 4'd1, 32'd2000000, '0, "R6 dec");
    cmd(3'd5, 4'd1, 0, '0, "R6 xfer");
    cmd(3'd0, 4'd1, 0, '0, "R6 readback");
    chk("R6 negative", rd_data_o, mk(32'd1235567 - 32'd2000000, 8'h11));
    // R5 wrap and R6 wrap
    cmd(3'd1, 4'd3, 0, mk(32'hFFFF_FFFF, 8'h03), "R5 setup wrap");
    cmd(3'd2, 4'd3, 32'd1, '0, "R5 inc wrap");
    cmd(3'd5, 4'd3, 0, '0, "R5 xfer wrap");
    cmd(3'd3, 4'd3, 32'd1, '0, "R6 dec wrap");
    cmd(3'd5, 4'd3, 0, '0, "R6 xfer wrap");
    cmd(3'd0, 4'd3, 0, '0, "R6 wrap read");
    chk("R6 wrap value", rd_data_o, mk(32'hFFFF_FFFF, 8'h03));
    // R4 corrupt value copy, then R9 transfer refused
    cmd(3'd1, 4'd4, 0, mk(32'd77, 8'h04) ^ 128'h1_0000_0000_0000_0000, "R4 setup bad");
    cmd(3'd2, 4'd4, 32'd5, '0, "R4 inc bad");
    cmd(3'd5, 4'd1, 0, '0, "R9 xfer after error");
    cmd(3'd0, 4'd1, 0, '0, "R9 bank unchanged");
    // R4 corrupt address only
    cmd(3'd1, 4'd5, 0, mk(32'd9, 8'h05) ^ {8'h01, 120'h0}, "R4 setup bad adr");
    cmd(3'd4, 4'd5, 0, '0, "R4 restore bad adr");
    // R9 transfer into a malformed target with valid register
    cmd(3'd4, 4'd1, 0, '0, "R7 restore again");
    cmd(3'd5, 4'd5, 0, '0, "R9 xfer bad target");
    cmd(3'd0, 4'd5, 0, '0, "R9 bad target unchanged");
    // R10 illegal codes
    cmd(3'd4, 4'd1, 0, '0, "R7 restore valid");
    cmd(3'd6, 4'd1, 0, mk(32'd1, 8'h01), "R10 code6");
    cmd(3'd7, 4'd1, 0, mk(32'd1, 8'h01), "R10 code7");
    cmd(3'd0, 4'd1, 0, '0, "R10 block unchanged");
    cmd(3'd5, 4'd1, 0, '0, "R10 register invalidated");
    // R11 back-to-back on same block
    cmd(3'd1, 4'd6, 0, mk(32'd40, 8'h06), "R11 write");
    cmd(3'd2, 4'd6, 32'd2, '0, "R11 inc after write");
    cmd(3'd5, 4'd6, 0, '0, "R11 xfer");
    cmd(3'd0, 4'd6, 0, '0, "R11 read after xfer");
    chk("R11 value", rd_data_o, mk(32'd42, 8'h06));
    idle(3);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule